// File: doc/BRIEF.md
# Dual Programmable Timer Counter

This peripheral holds two independent 32-bit timer/counter channels. Software reaches them through a small word-addressed register bus. Each channel has three registers: a control/status word, a reload/capture register and a live counter. A channel can count up or down. It can reload itself on terminal count, take a snapshot of its counter when an external signal rises, and raise an interrupt through a sticky flag. Writing 1 to that flag clears it.

There are three operating modes. Generate mode gives periodic or one-shot event pulses. Capture mode timestamps external edges into the reload register. In PWM mode the two channels combine to drive one output: channel 0 sets the period and channel 1's reload value sets the high time.

Top module: `dual_tmr_top`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0, the mode is generate, and gen_out, irq and pwm_out are low.
- R2: bus_addr[2] selects the channel and bus_addr[1:0] selects the register: 0 control, 1 reload, 2 counter. Reload and counter are fully writable and read back what was written.
- R3: Control bit 0 enables counting. Bit 1 selects down (1) or up (0). An enabled counter moves one step per clock, and a disabled counter holds its value.
- R4: Writing control with bit 4 set copies the reload register into the counter at the clock that takes the write. Bit 4 always reads back as 0.
- R5: Control bits [6:5] select the mode: 1 capture, 2 PWM, 0 or 3 generate. When an enabled counter sits at its terminal value, an event occurs. The terminal value is all ones when counting up and zero when counting down. With auto-reload (bit 2) set, the event reloads the counter from the reload register, so a down count repeats every reload+1 clocks. In generate mode each event gives a one-cycle gen_out pulse.
- R6: In generate mode without auto-reload, an event clears the enable bit and the counter stays at its terminal value.
- R7: In capture mode, a rising edge on cap_in reaches the channel after a two-flop synchronizer. That edge copies the counter into the reload register and sets the flag. Falling edges, and edges seen in other modes, change nothing.
- R8: When both channels are in PWM mode and channel 0 is enabled, pwm_out is high while channel 0's counter is below channel 1's reload value. With channel 0 counting down with auto-reload, this gives a period of reload0+1 clocks and a high time of reload1 clocks. Channel 1's counter is frozen in this pairing. Otherwise pwm_out is low.
- R9: Control bit 7 is the interrupt flag. Generate and PWM events set it, and so do capture edges. Writing 1 to it clears it, and a set in the same cycle wins over the clear.
- R10: irq for a channel is high exactly when its flag is set and its interrupt enable (control bit 3) is set.
- R11: Read data appears on bus_rdata one clock after bus_rd is sampled. Register index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Channel bit and register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| gen_out | output | 2 | One-cycle generate pulses, one per channel |
| pwm_out | output | 1 | Paired PWM output |
| irq | output | 2 | Interrupt requests, one per channel |

## Verification
The assertions watch several rules on every clock. Each step of an enabled counter away from its terminal value must be exactly one. A generate pulse must coincide with a set flag. A one-shot event must drop the enable bit. A synchronized capture edge must land the counter value in the reload register. A write-1 clear must empty the flag. pwm_out must stay low whenever the pairing is inactive. Other properties need whole sequences and only the bench scenarios can show them. These are the auto-reload period, the PWM duty over full periods, the fact that falling or out-of-mode capture edges are ignored, the interrupt gating by the enable bit, and the read-back layout of the control word.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    MODE_GEN  = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_GEN3 = 2'd3
  } mode_e;

  localparam int B_EN   = 0;
  localparam int B_DOWN = 1;
  localparam int B_ARLD = 2;
  localparam int B_IE   = 3;
  localparam int B_LOAD = 4;
  localparam int B_MODE = 5;
  localparam int B_FLAG = 7;
  localparam int CTRL_W = 8;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_LOAD = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
endpackage

// File: rtl/dtc_edge_sync.sv
module dtc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], din};
  end

  assign rise = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/dtc_pwm.sv
module dtc_pwm #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] high_time,
  output logic          pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= active && (cnt < high_time);
  end
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
  import dtc_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              load_wr,
  input  logic              cnt_wr,
  input  logic [CW-1:0]     wdata,
  input  logic              cap_edge,
  input  logic              hold,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     load_q,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              en_q,
  output logic              dn_q,
  output logic              arld_q,
  output logic              ie_q,
  output logic              flag_q,
  output mode_e             mode_q,
  output logic              gen_q,
  output logic              irq
);
  logic          terminal, run, evt, is_cap, is_pwm, is_gen, cap_hit, flag_set;
  logic [CW-1:0] cnt_step;

  always_comb begin
    terminal = dn_q ? (cnt_q == '0) : (cnt_q == '1);
    run      = en_q && !hold;
    evt      = run && terminal;
    cnt_step = dn_q ? cnt_q - CW'(1) : cnt_q + CW'(1);
    is_cap   = (mode_q == MODE_CAP);
    is_pwm   = (mode_q == MODE_PWM);
    is_gen   = !is_cap && !is_pwm;
    cap_hit  = is_cap && cap_edge;
    flag_set = (evt && !is_cap) || cap_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      en_q   <= 1'b0;
      dn_q   <= 1'b0;
      arld_q <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      mode_q <= MODE_GEN;
      gen_q  <= 1'b0;
    end else begin
      gen_q <= evt && is_gen;

      if (cnt_wr) begin
        cnt_q <= wdata;
      end else if (ctrl_wr && wdata[B_LOAD]) begin
        cnt_q <= load_q;
      end else if (run) begin
        if (terminal) begin
          if (arld_q)       cnt_q <= load_q;
          else if (!is_gen) cnt_q <= cnt_step;
        end else begin
          cnt_q <= cnt_step;
        end
      end

      if (evt && is_gen && !arld_q) en_q <= 1'b0;

      if (load_wr)      load_q <= wdata;
      else if (cap_hit) load_q <= cnt_q;

      if (ctrl_wr) begin
        en_q   <= wdata[B_EN];
        dn_q   <= wdata[B_DOWN];
        arld_q <= wdata[B_ARLD];
        ie_q   <= wdata[B_IE];
        mode_q <= mode_e'(wdata[B_MODE +: 2]);
      end

      if (flag_set)                      flag_q <= 1'b1;
      else if (ctrl_wr && wdata[B_FLAG]) flag_q <= 1'b0;
    end
  end

  assign irq     = flag_q & ie_q;
  assign ctrl_rd = {flag_q, mode_q, 1'b0, ie_q, arld_q, dn_q, en_q};
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
  import dtc_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic [1:0]    cap_in,
  output logic [1:0]    gen_out,
  output logic          pwm_out,
  output logic [1:0]    irq
);
  localparam int NCH = 2;
  localparam int AW  = 3;

  logic [NCH-1:0]             ctrl_wr_v, load_wr_v, cnt_wr_v, cap_edge_v, hold_v;
  logic [NCH-1:0]             en_v, dn_v, arld_v, ie_v, flag_v, gen_v, irq_v;
  logic [NCH-1:0][CW-1:0]     cnt_v, load_v;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_v;
  logic [NCH-1:0][1:0]        mode_v;
  logic                       pwm_pair, pwm_active;

  assign pwm_pair   = (mode_v[0] == MODE_PWM) && (mode_v[1] == MODE_PWM);
  assign pwm_active = pwm_pair && en_v[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    mode_e mode_w;
    assign sel          = (bus_addr[AW-1] == 1'(i));
    assign ctrl_wr_v[i] = bus_wr && sel && (bus_addr[1:0] == IDX_CTRL);
    assign load_wr_v[i] = bus_wr && sel && (bus_addr[1:0] == IDX_LOAD);
    assign cnt_wr_v[i]  = bus_wr && sel && (bus_addr[1:0] == IDX_CNT);
    assign hold_v[i]    = (i == 1) ? pwm_pair : 1'b0;
    assign mode_v[i]    = mode_w;

    dtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (cap_in[i]),
      .rise(cap_edge_v[i])
    );

    dtc_channel #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .ctrl_wr (ctrl_wr_v[i]),
      .load_wr (load_wr_v[i]),
      .cnt_wr  (cnt_wr_v[i]),
      .wdata   (bus_wdata),
      .cap_edge(cap_edge_v[i]),
      .hold    (hold_v[i]),
      .cnt_q   (cnt_v[i]),
      .load_q  (load_v[i]),
      .ctrl_rd (ctrl_v[i]),
      .en_q    (en_v[i]),
      .dn_q    (dn_v[i]),
      .arld_q  (arld_v[i]),
      .ie_q    (ie_v[i]),
      .flag_q  (flag_v[i]),
      .mode_q  (mode_w),
      .gen_q   (gen_v[i]),
      .irq     (irq_v[i])
    );
  end

  dtc_pwm #(.CW(CW)) u_pwm (
    .clk      (clk),
    .rst      (rst),
    .active   (pwm_active),
    .cnt      (cnt_v[0]),
    .high_time(load_v[1]),
    .pwm_q    (pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr[1:0])
        IDX_CTRL: bus_rdata <= CW'(ctrl_v[bus_addr[AW-1]]);
        IDX_LOAD: bus_rdata <= load_v[bus_addr[AW-1]];
        IDX_CNT:  bus_rdata <= cnt_v[bus_addr[AW-1]];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign gen_out = gen_v;
  assign irq     = irq_v;
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int CW = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          ctrl_wr,
  input logic [1:0]          load_wr,
  input logic [1:0]          cnt_wr,
  input logic                wflag,
  input logic [1:0]          cap_edge,
  input logic [1:0]          hold,
  input logic [1:0]          en,
  input logic [1:0]          dn,
  input logic [1:0]          arld,
  input logic [1:0]          flag,
  input logic [1:0][1:0]     mode,
  input logic [1:0][CW-1:0]  cnt,
  input logic [1:0][CW-1:0]  load,
  input logic [1:0]          gen_out,
  input logic                pwm_active,
  input logic                pwm_out
);
  for (genvar i = 0; i < 2; i++) begin : g_chk
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
      (en[i] && !hold[i] && !cnt_wr[i] && !ctrl_wr[i] && cnt[i] != '0 && cnt[i] != '1)
      |=> cnt[i] == ($past(dn[i]) ? $past(cnt[i]) - CW'(1) : $past(cnt[i]) + CW'(1)));

    p_gen_flag_r5: assert property (@(posedge clk) disable iff (rst)
      gen_out[i] |-> flag[i]);

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
      (gen_out[i] && !arld[i] && !$past(ctrl_wr[i])) |-> !en[i]);

    p_cap_copy_r7: assert property (@(posedge clk) disable iff (rst)
      (cap_edge[i] && mode[i] == 2'd1 && !load_wr[i]) |=> load[i] == $past(cnt[i]));

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr[i] && wflag && !en[i] && mode[i] != 2'd1) |=> !flag[i]);
  end

  p_pwm_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !pwm_active |=> !pwm_out);
endmodule

bind dual_tmr_top dtc_checker #(.CW(CW)) u_dtc_checker (
  .clk       (clk),
  .rst       (rst),
  .ctrl_wr   (ctrl_wr_v),
  .load_wr   (load_wr_v),
  .cnt_wr    (cnt_wr_v),
  .wflag     (bus_wdata[7]),
  .cap_edge  (cap_edge_v),
  .hold      (hold_v),
  .en        (en_v),
  .dn        (dn_v),
  .arld      (arld_v),
  .flag      (flag_v),
  .mode      (mode_v),
  .cnt       (cnt_v),
  .load      (load_v),
  .gen_out   (gen_out),
  .pwm_active(pwm_active),
  .pwm_out   (pwm_out)
);

// File: tb/test_dual_tmr_top.sv
module test_dual_tmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic [1:0]  gen_out, irq;
  logic        pwm_out;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  localparam logic [31:0] EN = 1, DN = 2, ARLD = 4, IE = 8, LD = 16, CAP = 32, PWM = 64, FLG = 128;

  always #4 clk = ~clk;

  dual_tmr_top i_dual_tmr_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .gen_out(gen_out), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // scoreboard monitor: read data is registered, so compare at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(bus_rdata === e, t, bus_rdata, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int highs, pos, run, maxrun, irq_seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R11 reserved index
    check(gen_out == 2'b00 && irq == 2'b00 && pwm_out == 1'b0, "R1 outputs", {29'd0, gen_out, pwm_out}, 0);
    rd(3'd0, 0, "R1 ctrl0"); rd(3'd1, 0, "R1 load0"); rd(3'd2, 0, "R1 cnt0");
    rd(3'd4, 0, "R1 ctrl1"); rd(3'd6, 0, "R1 cnt1"); rd(3'd3, 0, "R11 reserved");

    // R2 register access
    wr(3'd1, 32'hA5A5_0001); rd(3'd1, 32'hA5A5_0001, "R2 load rw");
    wr(3'd6, 32'd123);       rd(3'd6, 32'd123, "R2 cnt rw");

    // R3 up, hold, down
    wr(3'd2, 32'd10); wr(3'd0, EN);
    repeat (4) @(negedge clk);
    wr(3'd0, 0); rd(3'd2, 32'd15, "R3 up count");
    repeat (3) @(negedge clk);
    rd(3'd2, 32'd15, "R3 disabled hold");
    wr(3'd2, 32'd10); wr(3'd0, EN | DN);
    repeat (4) @(negedge clk);
    wr(3'd0, DN); rd(3'd2, 32'd5, "R3 down count");

    // R4 load bit
    wr(3'd1, 32'd100); wr(3'd0, LD);
    rd(3'd2, 32'd100, "R4 load copy"); rd(3'd0, 0, "R4 load bit reads 0");

    // R6 one-shot down, gen pulse in 4th cycle
    wr(3'd2, 32'd3); wr(3'd0, EN | DN | IE);
    highs = 0; pos = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (gen_out[0]) begin highs++; pos = k; end
    end
    check(highs == 1 && pos == 4, "R5 one-shot pulse", highs * 100 + pos, 104);
    check(irq[0] == 1'b1, "R10 irq with enable", {31'd0, irq[0]}, 1);
    rd(3'd0, FLG | IE | DN, "R6 enable cleared");
    rd(3'd2, 0, "R6 counter held at terminal");

    // R9 write-1 clear
    wr(3'd0, FLG | IE | DN);
    check(irq[0] == 1'b0, "R9 flag cleared", {31'd0, irq[0]}, 0);
    rd(3'd0, IE | DN, "R9 ctrl after clear");

    // up one-shot from near all-ones, interrupt disabled
    wr(3'd2, 32'hFFFF_FFFE); wr(3'd0, EN);
    highs = 0; pos = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (gen_out[0]) begin highs++; pos = k; end
    end
    check(highs == 1 && pos == 2, "R5 up terminal pulse", highs * 100 + pos, 102);
    check(irq[0] == 1'b0, "R10 irq masked", {31'd0, irq[0]}, 0);
    rd(3'd0, FLG, "R6 up flag set enable cleared");
    rd(3'd2, 32'hFFFF_FFFF, "R6 up counter held");
    wr(3'd0, FLG);

    // R5 auto-reload period 3
    wr(3'd1, 32'd2); wr(3'd2, 32'd2); wr(3'd0, EN | DN | ARLD);
    highs = 0; irq_seen = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (gen_out[0]) highs++;
      if (irq[0]) irq_seen++;
    end
    check(highs == 10, "R5 reload period", highs, 10);
    check(irq_seen == 0, "R10 masked during reload", irq_seen, 0);
    wr(3'd0, DN | ARLD | FLG);

    // R7 capture on channel 1
    wr(3'd6, 32'h55); wr(3'd4, CAP | IE);
    cap_in[1] = 1'b1;
    repeat (6) @(negedge clk);
    check(irq[1] == 1'b1, "R7 capture flag", {31'd0, irq[1]}, 1);
    rd(3'd5, 32'h55, "R7 captured value");
    wr(3'd6, 32'h77); wr(3'd4, CAP | IE | FLG);
    cap_in[1] = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd5, 32'h55, "R7 falling edge ignored");
    check(irq[1] == 1'b0, "R7 no flag on fall", {31'd0, irq[1]}, 0);
    wr(3'd4, IE);
    cap_in[1] = 1'b1;
    repeat (6) @(negedge clk);
    rd(3'd5, 32'h55, "R7 ignored outside capture mode");
    check(irq[1] == 1'b0, "R7 no flag outside mode", {31'd0, irq[1]}, 0);
    cap_in[1] = 1'b0;

    // R8 PWM: period 10, high 3
    wr(3'd5, 32'd3); wr(3'd4, PWM);
    wr(3'd1, 32'd9); wr(3'd2, 32'd9); wr(3'd0, PWM | EN | DN | ARLD);
    repeat (5) @(negedge clk);
    highs = 0; run = 0; maxrun = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (pwm_out) begin highs++; run++; if (run > maxrun) maxrun = run; end
      else run = 0;
    end
    check(highs == 15, "R8 duty over five periods", highs, 15);
    check(maxrun == 3, "R8 high time", maxrun, 3);
    rd(3'd6, 32'h77, "R8 channel 1 counter frozen");
    wr(3'd4, 0);
    repeat (3) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check(highs == 0, "R8 low when unpaired", highs, 0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule